// File: doc/BRIEF.md
# Soft-Decision Symbol Formatter with Node Sync

The block sits in front of a Viterbi branch-metric unit. Received symbols arrive as 3-bit soft decisions. Each symbol carries a polarity and a confidence. The block turns each symbol into a single signed metric. It then arranges the symbols of the current set, together with the kept previous set, into the slot order that a 2-bit node-sync state selects. Any symbol flagged as punctured becomes a zero-weight erasure.

Symbols come in through two write strobes. The first carries G1 and G2 with their puncture flags. The second carries G3. At rate 1/2 a set is complete on the G1/G2 write. At rate 1/3 the G1/G2 write only loads a holding register, and the set is complete on the later G3 write. For each completed set, the formatted metrics appear one cycle later with a one-cycle valid strobe. They hold until the next completed set.

Top module: `soft_sym_formatter`

## Requirements
- R1: With `sm_i`=1 (sign-magnitude), the codes 011,010,001,000,100,101,110,111 map to the metrics +7,+5,+3,+1,-1,-3,-5,-7.
- R2: With `sm_i`=0 (two's complement), the codes 011,010,001,000,111,110,101,100 map to the metrics +7,+5,+3,+1,-1,-3,-5,-7.
- R3: Hard decisions in sign-magnitude mode (bit 2 carries the data, the other bits are high) give +7 for 011 and -7 for 111. A positive metric stands for a transmitted 0, so a constant '+' input decodes to all zeros.
- R4: With `rate3_i`=0, a `g12_wr_i` pulse completes a set. `vld_o` is high for exactly the following cycle. `m2_o` is 0, and a `g3_wr_i` pulse produces no `vld_o`.
- R5: With `rate3_i`=1, a `g12_wr_i` pulse produces no `vld_o` and only stores G1, G2 and their flags. The next `g3_wr_i` pulse completes the set with those stored values.
- R6: At rate 1/2, with `ns_i` written as {a,b}, the outputs (`m0_o`,`m1_o`) are: 00 gives (G1n,G2n); 10 gives (G2n-1,G1n); 01 gives (G2n,G1n); 11 gives (G2n-1,G1n).
- R7: At rate 1/3 the outputs (`m0_o`,`m1_o`,`m2_o`) are: 00 gives (G1n,G2n,G3n); 10 gives (G3n-1,G1n,G2n); 01 gives (G2n-1,G3n-1,G1n).
- R8: The previous set (n-1) is the last completed set. It changes only when a set completes, and it is all zero after reset.
- R9: A G1 or G2 symbol whose puncture flag (`er1_i`, `er2_i`) is high is a 0 metric, in the current slot and later as an n-1 symbol.
- R10: At rate 1/3, `ns_i`=11 orders the set as 00 does and raises `bad_ns_o` together with `vld_o`. `bad_ns_o` is low for any other completed set.
- R11: After reset `vld_o` and `bad_ns_o` are 0 and all metric outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate3_i | input | 1 | 1: rate 1/3, 0: rate 1/2 |
| sm_i | input | 1 | 1: sign-magnitude input, 0: two's complement |
| ns_i | input | 2 | Node-sync state {a,b} |
| g12_wr_i | input | 1 | G1/G2 write strobe |
| g1_i | input | 3 | G1 soft symbol |
| g2_i | input | 3 | G2 soft symbol |
| er1_i | input | 1 | G1 punctured |
| er2_i | input | 1 | G2 punctured |
| g3_wr_i | input | 1 | G3 write strobe |
| g3_i | input | 3 | G3 soft symbol |
| vld_o | output | 1 | Formatted set valid, one cycle |
| m0_o | output | 4 | Slot 0 metric, signed |
| m1_o | output | 4 | Slot 1 metric, signed |
| m2_o | output | 4 | Slot 2 metric, signed |
| bad_ns_o | output | 1 | Invalid rate 1/3 sync state seen |

## Verification
The bench builds the block with the default 3-bit symbol width. With that width the full eight-level code space can be swept in both input formats, and each metric can be compared against a table written out from the requirements. The short set history lets every sync state be driven with known n-1 contents, including erased ones. It also lets the bench confirm that an unfinished rate 1/3 write leaves that history unchanged.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  parameter int SYM_W = 3;
  localparam int MET_W = SYM_W + 1;
  localparam int NSYM = 3;
  typedef logic signed [MET_W-1:0] met_t;
  typedef met_t [NSYM-1:0] mset_t;
  typedef enum logic [1:0] {
    NS_STRAIGHT = 2'b00,
    NS_SHIFT_A  = 2'b10,
    NS_SHIFT_B  = 2'b01,
    NS_ODD      = 2'b11
  } ns_e;
endpackage

// File: rtl/sdf_conv.sv
module sdf_conv
  import sdf_pkg::*;
(
  input  logic [SYM_W-1:0] code_i,
  input  logic             sm_i,
  output met_t             val_o
);
  logic [MET_W-1:0] mag;
  logic [MET_W-1:0] tc;

  // odd-level metric: magnitude m -> 2m+1
  assign mag = {1'b0, code_i[SYM_W-2:0], 1'b1};
  assign tc  = {code_i, 1'b1};

  always_comb begin
    if (sm_i) val_o = code_i[SYM_W-1] ? met_t'(-mag) : met_t'(mag);
    else      val_o = met_t'(tc);
  end
endmodule

// File: rtl/sdf_hist.sv
module sdf_hist
  import sdf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  mset_t cur_i,
  output mset_t prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_o <= '0;
    else if (upd_i) prev_o <= cur_i;
  end

  a_r8_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(prev_o));
endmodule

// File: rtl/sdf_order.sv
module sdf_order
  import sdf_pkg::*;
(
  input  logic       rate3_i,
  input  logic [1:0] ns_i,
  input  mset_t      cur_i,
  input  mset_t      prev_i,
  output mset_t      set_o,
  output logic       bad_o
);
  always_comb begin
    set_o = '0;
    bad_o = 1'b0;
    if (!rate3_i) begin
      unique case (ns_e'(ns_i))
        NS_STRAIGHT: begin set_o[0] = cur_i[0];  set_o[1] = cur_i[1]; end
        NS_SHIFT_B:  begin set_o[0] = cur_i[1];  set_o[1] = cur_i[0]; end
        default:     begin set_o[0] = prev_i[1]; set_o[1] = cur_i[0]; end
      endcase
    end else begin
      unique case (ns_e'(ns_i))
        NS_SHIFT_A: begin
          set_o[0] = prev_i[2]; set_o[1] = cur_i[0]; set_o[2] = cur_i[1];
        end
        NS_SHIFT_B: begin
          set_o[0] = prev_i[1]; set_o[1] = prev_i[2]; set_o[2] = cur_i[0];
        end
        default: begin
          set_o = cur_i;
          bad_o = (ns_i == NS_ODD);
        end
      endcase
    end
  end
endmodule

// File: rtl/soft_sym_formatter.sv
module soft_sym_formatter
  import sdf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rate3_i,
  input  logic             sm_i,
  input  logic [1:0]       ns_i,
  input  logic             g12_wr_i,
  input  logic [SYM_W-1:0] g1_i,
  input  logic [SYM_W-1:0] g2_i,
  input  logic             er1_i,
  input  logic             er2_i,
  input  logic             g3_wr_i,
  input  logic [SYM_W-1:0] g3_i,
  output logic             vld_o,
  output met_t             m0_o,
  output met_t             m1_o,
  output met_t             m2_o,
  output logic             bad_ns_o
);
  logic [SYM_W-1:0] h_g1, h_g2;
  logic             h_e1, h_e2;
  logic [NSYM-1:0][SYM_W-1:0] raw;
  logic [1:0]       ers;
  mset_t            cv, cur, prev, ord;
  logic             bad, fire;

  // G1/G2 holding register for rate 1/3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_g1 <= '0; h_g2 <= '0; h_e1 <= 1'b0; h_e2 <= 1'b0;
    end else if (g12_wr_i) begin
      h_g1 <= g1_i; h_g2 <= g2_i; h_e1 <= er1_i; h_e2 <= er2_i;
    end
  end

  assign fire   = rate3_i ? g3_wr_i : g12_wr_i;
  assign raw[0] = rate3_i ? h_g1 : g1_i;
  assign raw[1] = rate3_i ? h_g2 : g2_i;
  assign raw[2] = g3_i;
  assign ers    = rate3_i ? {h_e2, h_e1} : {er2_i, er1_i};

  for (genvar k = 0; k < NSYM; k++) begin : g_conv
    sdf_conv u_conv (.code_i(raw[k]), .sm_i(sm_i), .val_o(cv[k]));
    if (k < 2) begin : g_punc
      assign cur[k] = ers[k] ? met_t'(0) : cv[k];
    end else begin : g_nopunc
      assign cur[k] = rate3_i ? cv[k] : met_t'(0);
    end
  end

  sdf_hist u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(fire), .cur_i(cur), .prev_o(prev)
  );

  sdf_order u_order (
    .rate3_i(rate3_i), .ns_i(ns_i), .cur_i(cur), .prev_i(prev),
    .set_o(ord), .bad_o(bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0; bad_ns_o <= 1'b0;
      m0_o <= '0; m1_o <= '0; m2_o <= '0;
    end else begin
      vld_o <= fire;
      if (fire) begin
        m0_o <= ord[0]; m1_o <= ord[1]; m2_o <= ord[2];
        bad_ns_o <= bad;
      end else begin
        bad_ns_o <= 1'b0;
      end
    end
  end

  a_r4_m2_zero_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g12_wr_i && !rate3_i) |=> (vld_o && m2_o == '0));
  a_r5_g12_no_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate3_i && g12_wr_i && !g3_wr_i) |=> !vld_o);
  a_r6_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g12_wr_i && !rate3_i && ns_i == 2'b01) |=>
      (m0_o == $past(cur[1]) && m1_o == $past(cur[0])));
  a_r9_erase_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g12_wr_i && !rate3_i && er1_i && ns_i == 2'b00) |=> m0_o == '0);
  a_r10_bad_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g3_wr_i && rate3_i && ns_i == 2'b11) |=> bad_ns_o);
  a_r10_bad_only_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_ns_o |-> vld_o);
endmodule

// File: tb/soft_sym_formatter_test.sv
`timescale 1ns/1ps
module soft_sym_formatter_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic rate3 = 1'b0, sm = 1'b1;
  logic [1:0] ns = 2'b00;
  logic g12_wr = 1'b0, g3_wr = 1'b0, er1 = 1'b0, er2 = 1'b0;
  logic [2:0] g1 = '0, g2 = '0, g3 = '0;
  logic vld, bad;
  logic signed [3:0] m0, m1, m2;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // bench model state
  int p0 = 0, p1 = 0, p2 = 0;
  logic [2:0] hg1 = '0, hg2 = '0;
  logic he1 = 1'b0, he2 = 1'b0;

  always #2.5 clk = ~clk;

  soft_sym_formatter uut (
    .clk_i(clk), .rst_ni(rst_ni), .rate3_i(rate3), .sm_i(sm), .ns_i(ns),
    .g12_wr_i(g12_wr), .g1_i(g1), .g2_i(g2), .er1_i(er1), .er2_i(er2),
    .g3_wr_i(g3_wr), .g3_i(g3), .vld_o(vld), .m0_o(m0), .m1_o(m1),
    .m2_o(m2), .bad_ns_o(bad)
  );

  function automatic int lvl(input logic [2:0] c, input logic s);
    // level index 0..7 from most confident '+' to most confident '-'
    int idx = 0;
    if (s) case (c)
      3'b011: idx = 0; 3'b010: idx = 1; 3'b001: idx = 2; 3'b000: idx = 3;
      3'b100: idx = 4; 3'b101: idx = 5; 3'b110: idx = 6; default: idx = 7;
    endcase
    else case (c)
      3'b011: idx = 0; 3'b010: idx = 1; 3'b001: idx = 2; 3'b000: idx = 3;
      3'b111: idx = 4; 3'b110: idx = 5; 3'b101: idx = 6; default: idx = 7;
    endcase
    return 7 - 2 * idx;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_set(input int c0, input int c1, input int c2, input string req);
    int e0, e1, e2;
    bit eb = 0;
    e2 = 0;
    if (!rate3) begin
      case (ns)
        2'b00: begin e0 = c0; e1 = c1; end
        2'b01: begin e0 = c1; e1 = c0; end
        default: begin e0 = p1; e1 = c0; end
      endcase
    end else begin
      case (ns)
        2'b10: begin e0 = p2; e1 = c0; e2 = c1; end
        2'b01: begin e0 = p1; e1 = p2; e2 = c0; end
        default: begin e0 = c0; e1 = c1; e2 = c2; eb = (ns == 2'b11); end
      endcase
    end
    chk(vld == 1'b1, {req, " vld"}, int'(vld), 1);
    chk(int'(m0) == e0, {req, " m0"}, int'(m0), e0);
    chk(int'(m1) == e1, {req, " m1"}, int'(m1), e1);
    chk(int'(m2) == e2, {req, " m2"}, int'(m2), e2);
    chk(bad == eb, {req, " bad_ns"}, int'(bad), int'(eb));
    p0 = c0; p1 = c1; p2 = c2;
  endtask

  task automatic w12(input logic [2:0] a, input logic [2:0] b,
                     input logic ea, input logic eb, input string req);
    g1 = a; g2 = b; er1 = ea; er2 = eb; g12_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    g12_wr = 1'b0; er1 = 1'b0; er2 = 1'b0;
    if (rate3) begin
      hg1 = a; hg2 = b; he1 = ea; he2 = eb;
      chk(vld == 1'b0, "R5 no vld on G1/G2 write", int'(vld), 0);
    end else begin
      check_set(ea ? 0 : lvl(a, sm), eb ? 0 : lvl(b, sm), 0, req);
    end
  endtask

  task automatic w3(input logic [2:0] c, input string req);
    g3 = c; g3_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    g3_wr = 1'b0;
    if (rate3) check_set(he1 ? 0 : lvl(hg1, sm), he2 ? 0 : lvl(hg2, sm), lvl(c, sm), req);
    else chk(vld == 1'b0, "R4 G3 write ignored", int'(vld), 0);
  endtask

  task automatic t_reset();
    chk(vld == 1'b0, "R11 vld reset", int'(vld), 0);
    chk(bad == 1'b0, "R11 bad reset", int'(bad), 0);
    chk(m0 == 0 && m1 == 0 && m2 == 0, "R11 metrics reset", int'(m0), 0);
  endtask

  task automatic t_history_reset();
    // R8: n-1 is zero after reset
    rate3 = 1'b0; sm = 1'b1; ns = 2'b10;
    w12(3'b011, 3'b010, 1'b0, 1'b0, "R8 zero history after reset");
  endtask

  task automatic t_sm();
    rate3 = 1'b0; sm = 1'b1; ns = 2'b00;
    for (int c = 0; c < 8; c++) w12(3'(c), 3'(7 - c), 1'b0, 1'b0, "R1 sign-magnitude");
    @(negedge clk);
    chk(vld == 1'b0, "R4 vld single cycle", int'(vld), 0);
  endtask

  task automatic t_tc();
    rate3 = 1'b0; sm = 1'b0; ns = 2'b00;
    for (int c = 0; c < 8; c++) w12(3'(c), 3'(c + 3), 1'b0, 1'b0, "R2 two's complement");
  endtask

  task automatic t_hard();
    rate3 = 1'b0; sm = 1'b1; ns = 2'b00;
    w12(3'b011, 3'b011, 1'b0, 1'b0, "R3 hard plus");
    chk(m0 > 0 && m1 > 0, "R3 plus gives zero-bit polarity", int'(m0), 7);
    w12(3'b111, 3'b011, 1'b0, 1'b0, "R3 hard minus");
  endtask

  task automatic t_r12_order();
    rate3 = 1'b0; sm = 1'b1;
    ns = 2'b10; w12(3'b001, 3'b110, 1'b0, 1'b0, "R6 sync 10");
    w3(3'b011, "R4");
    ns = 2'b01; w12(3'b101, 3'b010, 1'b0, 1'b0, "R6 sync 01");
    ns = 2'b11; w12(3'b000, 3'b111, 1'b0, 1'b0, "R6 sync 11");
    ns = 2'b10; w12(3'b100, 3'b011, 1'b0, 1'b0, "R6 sync 10 again");
  endtask

  task automatic t_r13();
    rate3 = 1'b1; sm = 1'b1; ns = 2'b00;
    w12(3'b011, 3'b001, 1'b0, 1'b0, "R5");
    w3(3'b110, "R7 sync 00");
    w12(3'b010, 3'b101, 1'b0, 1'b0, "R5");
    ns = 2'b10; w3(3'b000, "R7 sync 10");
    w12(3'b111, 3'b100, 1'b0, 1'b0, "R5");
    // R8: G1/G2 write did not advance n-1
    ns = 2'b01; w3(3'b011, "R7 sync 01 / R8 history");
  endtask

  task automatic t_punc();
    rate3 = 1'b0; sm = 1'b1; ns = 2'b00;
    w12(3'b011, 3'b110, 1'b1, 1'b0, "R9 G1 erased");
    w12(3'b010, 3'b101, 1'b0, 1'b1, "R9 G2 erased");
    ns = 2'b10; w12(3'b001, 3'b001, 1'b0, 1'b0, "R9 erased as n-1");
    rate3 = 1'b1; ns = 2'b00;
    w12(3'b011, 3'b011, 1'b1, 1'b1, "R5");
    w3(3'b101, "R9 rate 1/3 both erased");
  endtask

  task automatic t_bad();
    rate3 = 1'b1; sm = 1'b0; ns = 2'b11;
    w12(3'b001, 3'b110, 1'b0, 1'b0, "R5");
    w3(3'b010, "R10 invalid state");
    ns = 2'b00;
    w12(3'b011, 3'b100, 1'b0, 1'b0, "R5");
    w3(3'b111, "R10 flag clears");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_history_reset();
    t_sm();
    t_tc();
    t_hard();
    t_r12_order();
    t_r13();
    t_punc();
    t_bad();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule